// File: doc/BRIEF.md
# Wake-on-LAN Frame Detector

This block sits beside an Ethernet receive path and watches the bytes of each incoming frame. Its job is to decide whether the frame should wake the system. Two kinds of frame can do that. In the strict mode, the frame must carry a wake pattern. The pattern is a run of six 0xFF bytes followed at once by sixteen back-to-back copies of the local 48-bit station address. In the relaxed mode, any good frame whose destination field equals the station address is enough.

A decision is only taken when the frame ends and the CRC checker reports the frame good. A pattern match sets a sticky pattern status flag. Either kind of wake event raises a wake interrupt flag. Software clears each flag by writing a one to its own clear input. When a new event and a clear arrive in the same cycle, the event wins.

The receive side marks a frame with a start strobe in a cycle of its own. The data bytes follow under a byte-valid strobe. An end strobe comes in a cycle of its own after the last byte and carries the frame-good flag.

Top module: `wol_wake_detector`

## Requirements
- R1: After reset, `magic_sts` and `wake_irq` are both 0.
- R2: A good frame with `pattern_en` set sets `magic_sts` and `wake_irq` when it contains the wake pattern. The pattern is six 0xFF bytes followed directly by sixteen copies of `station_addr`, each copy sent byte by byte with bits 47:40 first. The station address must contain no 0xFF byte.
- R3: The search for the pattern starts only at the 13th data byte of the frame, after the 6-byte destination and the 6-byte source fields. A pattern that begins inside those first 12 bytes is not detected.
- R4: Any number of other bytes may come before or after the pattern. A sync run longer than six 0xFF bytes still leads to a match. A 0xFF byte that breaks a partial match counts as the first byte of a new sync run.
- R5: While `pattern_en` is 0, no frame sets `magic_sts`, and no pattern match raises `wake_irq`.
- R6: A detection takes effect only on the `rx_eof` cycle, and only when `rx_frame_ok` is 1 in that cycle. A frame with `rx_frame_ok` 0 changes neither flag. Neither flag changes before the end strobe.
- R7: `rx_sof` discards any partial match, so a pattern split across two frames is not detected.
- R8: With `addr_wake_en` set, a good frame whose first six data bytes equal `station_addr` (bits 47:40 first) raises `wake_irq` and leaves `magic_sts` unchanged. A frame with a different destination raises nothing.
- R9: With `addr_wake_en` clear, a good frame whose destination matches but that carries no pattern raises nothing.
- R10: A 1 on `clr_magic` clears `magic_sts`, and a 1 on `clr_wake` clears `wake_irq`, in the next cycle. Each clear input affects only its own flag. With both clear inputs at 0, the flags hold their values.
- R11: When an event that sets a flag and a clear of that flag fall in the same cycle, the flag is 1 in the next cycle.
- R12: The flags change in the first cycle after the clock edge that samples `rx_eof`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_sof | input | 1 | Start-of-frame strobe, in a cycle without data |
| rx_valid | input | 1 | A data byte is present on rx_data |
| rx_data | input | 8 | Received byte |
| rx_eof | input | 1 | End-of-frame strobe, in a cycle after the last byte |
| rx_frame_ok | input | 1 | Frame-good flag from the CRC checker, sampled with rx_eof |
| station_addr | input | 48 | Local station address, bits 47:40 sent first |
| pattern_en | input | 1 | Enables wake-pattern detection |
| addr_wake_en | input | 1 | Enables waking on any frame addressed to the station |
| clr_magic | input | 1 | Write-one-to-clear for magic_sts |
| clr_wake | input | 1 | Write-one-to-clear for wake_irq |
| magic_sts | output | 1 | Sticky status: a wake pattern was seen |
| wake_irq | output | 1 | Sticky wake interrupt |

## Verification
The internal state that can go wrong is the pattern matcher's sync count and address position. A wrong value there does not show at the ports while the frame is running. It shows only at the next end-of-frame strobe, as a missing or unwanted flag. Because of that, the bench compares both flags with a reference model on every clock. It also feeds patterns that stretch, break and restart the matcher, so that a lost or stale count is seen at the frame's end strobe. A fault in the header counter or the destination compare shows in the same way, as a flag that is wrong one cycle after the end strobe.

// File: rtl/wol_pkg.sv
package wol_pkg;

  localparam int unsigned STA_BYTES = 6;
  localparam int unsigned STA_W     = STA_BYTES * 8;
  localparam logic [7:0]  SYNC_BYTE = 8'hFF;

  // Byte k of a station address in wire order (k = 0 is bits 47:40).
  function automatic logic [7:0] sta_byte(input logic [STA_W-1:0] a, input int unsigned k);
    return a[(STA_BYTES-1-k)*8 +: 8];
  endfunction

  function automatic logic is_sync(input logic [7:0] b);
    return b == SYNC_BYTE;
  endfunction

endpackage

// File: rtl/wol_hdr_track.sv
module wol_hdr_track
  import wol_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             sof,
  input  logic             valid,
  input  logic [7:0]       data,
  input  logic [STA_W-1:0] station_addr,
  output logic             payload_byte,
  output logic             dest_ok
);

  localparam int unsigned CW = $clog2(HDR_BYTES + 1);

  logic [CW-1:0]        cnt;
  logic                 dmatch;
  logic [STA_BYTES-1:0] byte_eq;
  logic                 in_dest;

  genvar g;
  generate
    for (g = 0; g < STA_BYTES; g++) begin : g_eq
      assign byte_eq[g] = (data == sta_byte(station_addr, g));
    end
  endgenerate

  assign in_dest      = cnt < CW'(STA_BYTES);
  assign payload_byte = valid && !sof && (cnt == CW'(HDR_BYTES));
  assign dest_ok      = dmatch && !in_dest;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt    <= '0;
      dmatch <= 1'b0;
    end else if (sof) begin
      cnt    <= '0;
      dmatch <= 1'b1;
    end else if (valid) begin
      if (cnt < CW'(HDR_BYTES)) cnt <= cnt + CW'(1);
      if (in_dest && !byte_eq[cnt]) dmatch <= 1'b0;
    end
  end

  assert_hdr_count_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(HDR_BYTES));

  assert_payload_after_header_R3: assert property (@(posedge clk) disable iff (!rst_n)
    payload_byte |-> $past(cnt) >= CW'(HDR_BYTES - 1));

endmodule

// File: rtl/wol_pattern_match.sv
module wol_pattern_match
  import wol_pkg::*;
#(
  parameter int unsigned SYNC_LEN = 6,
  parameter int unsigned REPEATS  = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             restart,
  input  logic             byte_en,
  input  logic [7:0]       data,
  input  logic [STA_W-1:0] station_addr,
  output logic             hit,
  output logic             found
);

  localparam int unsigned SW = $clog2(SYNC_LEN + 1);
  localparam int unsigned PW = (STA_BYTES > 1) ? $clog2(STA_BYTES) : 1;
  localparam int unsigned RW = (REPEATS > 1) ? $clog2(REPEATS) : 1;

  logic [SW-1:0] sync_cnt, sync_nx;
  logic [PW-1:0] pos, pos_nx;
  logic [RW-1:0] rep, rep_nx;
  logic          in_addr, exp_eq, last_byte, hit_nx;

  assign in_addr   = (sync_cnt == SW'(SYNC_LEN));
  assign exp_eq    = (data == sta_byte(station_addr, int'(pos)));
  assign last_byte = (pos == PW'(STA_BYTES - 1)) && (rep == RW'(REPEATS - 1));

  always_comb begin
    sync_nx = sync_cnt;
    pos_nx  = pos;
    rep_nx  = rep;
    hit_nx  = 1'b0;
    if (!in_addr) begin
      sync_nx = is_sync(data) ? sync_cnt + SW'(1) : '0;
      pos_nx  = '0;
      rep_nx  = '0;
    end else if (exp_eq) begin
      if (last_byte) begin
        hit_nx  = 1'b1;
        sync_nx = '0;
        pos_nx  = '0;
        rep_nx  = '0;
      end else if (pos == PW'(STA_BYTES - 1)) begin
        pos_nx = '0;
        rep_nx = rep + RW'(1);
      end else begin
        pos_nx = pos + PW'(1);
      end
    end else if (is_sync(data) && pos == '0 && rep == '0) begin
      sync_nx = sync_cnt;
    end else begin
      sync_nx = is_sync(data) ? SW'(1) : '0;
      pos_nx  = '0;
      rep_nx  = '0;
    end
  end

  assign hit = byte_en && !restart && hit_nx;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_cnt <= '0;
      pos      <= '0;
      rep      <= '0;
      found    <= 1'b0;
    end else if (restart) begin
      sync_cnt <= '0;
      pos      <= '0;
      rep      <= '0;
      found    <= 1'b0;
    end else if (byte_en) begin
      sync_cnt <= sync_nx;
      pos      <= pos_nx;
      rep      <= rep_nx;
      if (hit_nx) found <= 1'b1;
    end
  end

  assert_sync_bound_R4: assert property (@(posedge clk) disable iff (!rst_n)
    sync_cnt <= SW'(SYNC_LEN));

  assert_addr_pos_needs_sync_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_addr |-> (pos == '0 && rep == '0));

  assert_found_after_byte_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(found) |-> $past(byte_en && !restart));

  assert_restart_clears_R7: assert property (@(posedge clk) disable iff (!rst_n)
    restart |=> (!found && sync_cnt == '0));

endmodule

// File: rtl/wol_event_regs.sv
module wol_event_regs (
  input  logic clk,
  input  logic rst_n,
  input  logic set_magic,
  input  logic set_wake,
  input  logic clr_magic,
  input  logic clr_wake,
  output logic magic_sts,
  output logic wake_irq
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      magic_sts <= 1'b0;
      wake_irq  <= 1'b0;
    end else begin
      magic_sts <= set_magic | (magic_sts & ~clr_magic);
      wake_irq  <= set_wake  | (wake_irq  & ~clr_wake);
    end
  end

  assert_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_magic && clr_magic) |=> magic_sts);

  assert_wake_set_beats_clear_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (set_wake && clr_wake) |=> wake_irq);

  assert_clear_takes_effect_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (clr_magic && !set_magic) |=> !magic_sts);

  assert_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (magic_sts && !clr_magic) |=> magic_sts);

  assert_wake_sticky_hold_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (wake_irq && !clr_wake) |=> wake_irq);

endmodule

// File: rtl/wol_wake_detector.sv
module wol_wake_detector
  import wol_pkg::*;
#(
  parameter int unsigned HDR_BYTES = 12,
  parameter int unsigned SYNC_LEN  = 6,
  parameter int unsigned REPEATS   = 16
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             rx_sof,
  input  logic             rx_valid,
  input  logic [7:0]       rx_data,
  input  logic             rx_eof,
  input  logic             rx_frame_ok,
  input  logic [STA_W-1:0] station_addr,
  input  logic             pattern_en,
  input  logic             addr_wake_en,
  input  logic             clr_magic,
  input  logic             clr_wake,
  output logic             magic_sts,
  output logic             wake_irq
);

  logic payload_byte, dest_ok;
  logic match_restart, match_byte_en, match_hit, match_found;
  logic good_end, commit_magic, commit_addr, commit_wake;

  wol_hdr_track #(.HDR_BYTES(HDR_BYTES)) u_hdr (
    .clk          (clk),
    .rst_n        (rst_n),
    .sof          (rx_sof),
    .valid        (rx_valid),
    .data         (rx_data),
    .station_addr (station_addr),
    .payload_byte (payload_byte),
    .dest_ok      (dest_ok)
  );

  assign match_restart = rx_sof || !pattern_en;
  assign match_byte_en = payload_byte && pattern_en;

  wol_pattern_match #(.SYNC_LEN(SYNC_LEN), .REPEATS(REPEATS)) u_match (
    .clk          (clk),
    .rst_n        (rst_n),
    .restart      (match_restart),
    .byte_en      (match_byte_en),
    .data         (rx_data),
    .station_addr (station_addr),
    .hit          (match_hit),
    .found        (match_found)
  );

  assign good_end     = rx_eof && rx_frame_ok && !rx_sof;
  assign commit_magic = good_end && pattern_en && match_found;
  assign commit_addr  = good_end && addr_wake_en && dest_ok;
  assign commit_wake  = commit_magic || commit_addr;

  wol_event_regs u_regs (
    .clk       (clk),
    .rst_n     (rst_n),
    .set_magic (commit_magic),
    .set_wake  (commit_wake),
    .clr_magic (clr_magic),
    .clr_wake  (clr_wake),
    .magic_sts (magic_sts),
    .wake_irq  (wake_irq)
  );

  assert_magic_only_on_good_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(magic_sts) |-> $past(rx_eof && rx_frame_ok && pattern_en));

  assert_wake_only_on_good_end_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wake_irq) |-> $past(rx_eof && rx_frame_ok));

  assert_hit_only_in_payload_R3: assert property (@(posedge clk) disable iff (!rst_n)
    match_hit |-> payload_byte);

  assert_magic_implies_wake_R2: assert property (@(posedge clk) disable iff (!rst_n)
    commit_magic |=> wake_irq);

endmodule

// File: tb/test_wol_wake_detector.sv
module test_wol_wake_detector;

  localparam logic [47:0] STA = 48'h02_1A_3C_4D_5E_6F;
  localparam logic [47:0] OTHER = 48'h0A_0B_0C_0D_0E_0F;
  localparam int WATCHDOG = 100000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_sof = 0, rx_valid = 0, rx_eof = 0, rx_frame_ok = 0;
  logic [7:0] rx_data = '0;
  logic pattern_en = 0, addr_wake_en = 0, clr_magic = 0, clr_wake = 0;
  logic magic_sts, wake_irq;

  int checks = 0;
  int failures = 0;
  int cycles = 0;

  always #5 clk = ~clk;

  wol_wake_detector i_wol_wake_detector (
    .clk(clk), .rst_n(rst_n), .rx_sof(rx_sof), .rx_valid(rx_valid), .rx_data(rx_data),
    .rx_eof(rx_eof), .rx_frame_ok(rx_frame_ok), .station_addr(STA),
    .pattern_en(pattern_en), .addr_wake_en(addr_wake_en),
    .clr_magic(clr_magic), .clr_wake(clr_wake),
    .magic_sts(magic_sts), .wake_irq(wake_irq)
  );

  // ---------------- reference model ----------------
  logic [7:0] win[$];
  int  hdr_seen;
  bit  dest_hit, seen_pat, m_magic, m_wake;

  function automatic logic [7:0] addr_at(int k);
    return 8'((STA >> (8 * (5 - (k % 6)))) & 48'hFF);
  endfunction

  function automatic bit window_is_pattern();
    int n = win.size();
    if (n < 102) return 0;
    for (int k = 0; k < 6; k++) if (win[n - 102 + k] != 8'hFF) return 0;
    for (int k = 0; k < 96; k++) if (win[n - 96 + k] != addr_at(k)) return 0;
    return 1;
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      win.delete(); hdr_seen = 0; dest_hit = 0; seen_pat = 0;
      m_magic = 0; m_wake = 0;
    end else begin
      bit cm, ca;
      cm = rx_eof && rx_frame_ok && !rx_sof && pattern_en && seen_pat;
      ca = rx_eof && rx_frame_ok && !rx_sof && addr_wake_en && dest_hit && hdr_seen >= 6;
      m_magic = cm || (m_magic && !clr_magic);
      m_wake  = cm || ca || (m_wake && !clr_wake);
      if (rx_sof) begin
        win.delete(); hdr_seen = 0; dest_hit = 1; seen_pat = 0;
      end else if (rx_valid) begin
        if (hdr_seen < 6 && rx_data != addr_at(hdr_seen)) dest_hit = 0;
        if (hdr_seen >= 12 && pattern_en) begin
          win.push_back(rx_data);
          if (win.size() > 102) void'(win.pop_front());
          if (window_is_pattern()) seen_pat = 1;
        end
        hdr_seen++;
      end
      if (!pattern_en) begin win.delete(); seen_pat = 0; end
    end
  end

  always @(negedge clk) begin
    if (rst_n) begin
      checks++;
      if (magic_sts !== m_magic || wake_irq !== m_wake) begin
        failures++;
        $display("FAIL R2 model compare t=%0t: magic_sts=%b wake_irq=%b expected %b %b",
                 $time, magic_sts, wake_irq, m_magic, m_wake);
      end
    end
  end

  always @(posedge clk) begin
    cycles++;
    if (cycles > WATCHDOG) begin
      failures++;
      $display("FAIL watchdog: run exceeded %0d cycles, expected completion", WATCHDOG);
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  // ---------------- stimulus helpers ----------------
  logic [7:0] fb[$];

  task automatic check(input string req, input logic act, input logic exp, input string what);
    checks++;
    if (act !== exp) begin
      failures++;
      $display("FAIL %s %s: actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic push_addr(input logic [47:0] a);
    for (int k = 0; k < 6; k++) fb.push_back(8'((a >> (8 * (5 - k))) & 48'hFF));
  endtask
  task automatic push_ff(input int n);
    for (int k = 0; k < n; k++) fb.push_back(8'hFF);
  endtask
  task automatic push_copies(input int n);
    for (int k = 0; k < n; k++) push_addr(STA);
  endtask
  task automatic push_junk(input int n, input int seed);
    for (int k = 0; k < n; k++) fb.push_back(8'((seed * 7 + k * 13) % 200));
  endtask
  task automatic new_frame(input logic [47:0] dest);
    fb.delete(); push_addr(dest); push_addr(OTHER);
  endtask

  logic pre_magic, pre_wake;

  task automatic send(input bit ok, input bit clr_at_end);
    @(negedge clk); rx_sof = 1;
    @(negedge clk); rx_sof = 0;
    foreach (fb[i]) begin
      rx_valid = 1; rx_data = fb[i];
      @(negedge clk);
    end
    rx_valid = 0;
    @(negedge clk);
    pre_magic = magic_sts; pre_wake = wake_irq;
    rx_eof = 1; rx_frame_ok = ok; clr_magic = clr_at_end;
    @(negedge clk);
    rx_eof = 0; rx_frame_ok = 0; clr_magic = 0;
  endtask

  task automatic write_clr(input bit m, input bit w);
    clr_magic = m; clr_wake = w;
    @(negedge clk);
    clr_magic = 0; clr_wake = 0;
  endtask

  initial begin
    repeat (3) @(negedge clk);
    check("R1", magic_sts, 1'b0, "magic_sts in reset");
    check("R1", wake_irq, 1'b0, "wake_irq in reset");
    rst_n = 1;
    @(negedge clk);
    check("R1", magic_sts, 1'b0, "magic_sts after reset");
    check("R1", wake_irq, 1'b0, "wake_irq after reset");

    // R2/R12: plain pattern with filler around it
    pattern_en = 1;
    new_frame(OTHER); push_junk(9, 1); push_ff(6); push_copies(16); push_junk(5, 2);
    send(1, 0);
    check("R6", pre_magic, 1'b0, "magic_sts before end strobe");
    check("R12", magic_sts, 1'b1, "magic_sts one cycle after end strobe");
    check("R2", wake_irq, 1'b1, "wake_irq on pattern");

    // R10: zero write holds, clears are independent
    write_clr(0, 0);
    check("R10", magic_sts, 1'b1, "magic_sts after zero write");
    write_clr(1, 0);
    check("R10", magic_sts, 1'b0, "magic_sts after clear");
    check("R10", wake_irq, 1'b1, "wake_irq untouched by clr_magic");
    write_clr(0, 1);
    check("R10", wake_irq, 1'b0, "wake_irq after clear");

    // R6: bad CRC
    new_frame(OTHER); push_ff(6); push_copies(16);
    send(0, 0);
    check("R6", magic_sts, 1'b0, "bad frame magic_sts");
    check("R6", wake_irq, 1'b0, "bad frame wake_irq");

    // R3: pattern starting in the header
    fb.delete(); push_ff(6); push_copies(16);
    send(1, 0);
    check("R3", magic_sts, 1'b0, "pattern in header");

    // R7: pattern split over two frames
    new_frame(OTHER); push_ff(6); push_copies(10);
    send(1, 0);
    new_frame(OTHER); push_copies(6);
    send(1, 0);
    check("R7", magic_sts, 1'b0, "split pattern");

    // R4: long sync run
    new_frame(OTHER); push_ff(9); push_copies(16);
    send(1, 0);
    check("R4", magic_sts, 1'b1, "long sync run");
    write_clr(1, 1);

    // R4: 0xFF breaking a partial match starts a new sync
    new_frame(OTHER); push_ff(6); push_copies(3); fb.push_back(8'h02); push_ff(6); push_copies(16);
    send(1, 0);
    check("R4", magic_sts, 1'b1, "0xFF restart after break");
    write_clr(1, 1);

    // R4: broken by a non-FF byte and no restart, no detect
    new_frame(OTHER); push_ff(6); push_copies(8); fb.push_back(8'h33); push_copies(8);
    send(1, 0);
    check("R4", magic_sts, 1'b0, "broken pattern");

    // R5: detection disabled
    pattern_en = 0;
    new_frame(OTHER); push_ff(6); push_copies(16);
    send(1, 0);
    check("R5", magic_sts, 1'b0, "pattern with enable off");
    check("R5", wake_irq, 1'b0, "wake with enable off");

    // R9: strict mode ignores addressed frames without pattern
    pattern_en = 1;
    new_frame(STA); push_junk(20, 3);
    send(1, 0);
    check("R9", wake_irq, 1'b0, "addressed frame in strict mode");

    // R8: relaxed mode
    addr_wake_en = 1;
    new_frame(STA); push_junk(20, 4);
    send(1, 0);
    check("R8", wake_irq, 1'b1, "addressed frame wakes");
    check("R8", magic_sts, 1'b0, "addressed frame leaves magic_sts");
    write_clr(0, 1);
    new_frame(OTHER); push_junk(20, 5);
    send(1, 0);
    check("R8", wake_irq, 1'b0, "other destination");
    addr_wake_en = 0;

    // R11: set and clear in the same cycle
    new_frame(OTHER); push_ff(6); push_copies(16);
    send(1, 1);
    check("R11", magic_sts, 1'b1, "set wins over clear from 0");
    new_frame(OTHER); push_ff(6); push_copies(16);
    send(1, 1);
    check("R11", magic_sts, 1'b1, "set wins over clear from 1");
    write_clr(1, 1);
    check("R10", magic_sts, 1'b0, "final clear");

    repeat (3) @(negedge clk);
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule